// File: doc/BRIEF.md
# Four-Choice Arithmetic Quiz Controller

This block runs a push-button arithmetic quiz. A fixed store of 32 exercises, built into the logic as constants, is stepped through one exercise per answer. Each 32-bit exercise word holds two operands, the correct result and an operator code. A display path and a distractor generator elsewhere on the chip read that word. The controller places the correct result in one of four answer slots. The slot is chosen by sampling a free-running two-bit counter at the moment the player lets go of the buttons, so the choice depends on human timing and differs each time the quiz is played through.

Four active-low buttons enter through a two-flop synchronizer into a four-state game machine with these states:

| State | Meaning |
|---|---|
| `GS_BOOT` | Waits for the start press after reset. |
| `GS_BOOT_HELD` | The start press is down. Releasing it picks the first slot. |
| `GS_READY` | A question is shown and the machine waits for an answer. |
| `GS_HELD` | An answer was taken and the machine waits for every key to be released. |

The machine has four transitions:

- BOOT→BOOT_HELD on any key.
- BOOT_HELD→READY on release, which captures the slot.
- READY→HELD on any key, which grades the answer and advances the exercise.
- HELD→READY on release, which captures the slot.

A correct answer lights all nine green LEDs for a fixed number of cycles. That is 3 s at 50 MHz by default.

Top module: `quiz_ctrl`

## Requirements
- R1: After reset, `quiz_idx` is 0, `ans_slot` is 0, `answer_ok` is 0, `next_q` is 0, `glow_led` is all zero, and `quiz_word` shows exercise 0.
- R2: Keys are active-low and synchronized. A press is accepted only when all keys were released before it. When several keys go down together, the lowest index is taken. Keys added while a press is held are ignored.
- R3: The first press after reset only starts the game. It does not change `quiz_idx`, raises no `next_q`, and leaves `answer_ok` and `glow_led` at zero.
- R4: Each graded press raises `next_q` for exactly one cycle and advances `quiz_idx` by one. After index 31 the index wraps to 0, and `quiz_word` then equals the exercise shown after reset.
- R5: `quiz_word` layout is first operand [31:24], second operand [23:16], result [15:8] and operator [7:0]. Operator 0 is add, 1 is subtract, 2 is multiply and 3 is exact divide. The result field is always the operator applied to the operands.
- R6: `ans_slot` changes only on a release. It then takes the value of a two-bit counter that increments every cycle from reset. Two releases that are d cycles apart therefore give slots that differ by d mod 4.
- R7: `answer_ok` is set when the accepted key index equals the `ans_slot` that was in force before the press, and is cleared otherwise. It holds its value until the next graded press.
- R8: A correct answer drives all nine `glow_led` bits high for exactly HOLD_CYCLES cycles. A wrong answer does not light them.
- R9: A correct answer while the LEDs are lit restarts the full HOLD_CYCLES period from that answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n | input | 4 | Answer buttons, active-low, button i selects slot i |
| quiz_word | output | 32 | Current exercise word |
| quiz_idx | output | 5 | Current exercise index |
| ans_slot | output | 2 | Slot holding the correct answer |
| next_q | output | 1 | One-cycle pulse when the next exercise is loaded |
| answer_ok | output | 1 | Grade of the last answer |
| glow_led | output | 9 | Timed correct indication for the green LEDs |

## Verification
The slot is hard to steer from the ports because it depends on the absolute cycle at which the keys are released, counted from reset. The stimulus therefore varies the hold length of every press, and the bench notes the cycle of each release. It then predicts each new slot from the previous slot plus the distance between the two releases. Answers are built relative to the slot the bench reads back, so correct, wrong, simultaneous and late-added key patterns all occur on purpose. The bench measures the restart of the LED period by the gap between two correct presses.

// File: rtl/quiz_pkg.sv
package quiz_pkg;

    typedef enum logic [1:0] {
        GS_BOOT,
        GS_BOOT_HELD,
        GS_READY,
        GS_HELD
    } game_state_t;

    localparam logic [7:0] OP_ADD = 8'd0;
    localparam logic [7:0] OP_SUB = 8'd1;
    localparam logic [7:0] OP_MUL = 8'd2;
    localparam logic [7:0] OP_DIV = 8'd3;

    // Exercise n: second operand and quotient are spread by index,
    // results stay below 256 and divisions are exact.
    function automatic logic [31:0] exercise_word(input int unsigned n);
        int unsigned b;
        int unsigned q;
        int unsigned a;
        int unsigned r;
        logic [7:0]  op;
        b = (n % 9) + 2;
        q = ((n * 5) % 11) + 1;
        op = 8'(n % 4);
        case (op)
            OP_ADD: begin
                a = q * 3 + n;
                r = a + b;
            end
            OP_SUB: begin
                a = b + q;
                r = q;
            end
            OP_MUL: begin
                a = q;
                r = q * b;
            end
            default: begin
                a = q * b;
                r = q;
            end
        endcase
        return {a[7:0], b[7:0], r[7:0], op};
    endfunction

endpackage

// File: rtl/key_sync.sv
module key_sync #(
    parameter int KEYS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [KEYS-1:0] key_n,
    output logic [KEYS-1:0] key_act
);
    logic [KEYS-1:0] meta_q;
    logic [KEYS-1:0] sync_q;

    for (genvar g = 0; g < KEYS; g++) begin : g_key
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b1;
                sync_q[g] <= 1'b1;
            end else begin
                meta_q[g] <= key_n[g];
                sync_q[g] <= meta_q[g];
            end
        end
        assign key_act[g] = ~sync_q[g];
    end

endmodule

// File: rtl/slot_picker.sv
module slot_picker #(
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    output logic [SLOT_W-1:0] slot
);
    logic [SLOT_W-1:0] free_q;
    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_q <= '0;
            slot_q <= '0;
        end else begin
            free_q <= free_q + 1'b1;
            if (capture) slot_q <= free_q;
        end
    end

    assign slot = slot_q;

    // R6
    slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(slot_q));

endmodule

// File: rtl/exercise_rom.sv
module exercise_rom #(
    parameter int ENTRIES = 32,
    parameter int WORD_W  = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [AW-1:0]     idx,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] table_w [ENTRIES];
    logic [AW-1:0]     idx_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign table_w[g] = WORD_W'(quiz_pkg::exercise_word(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (advance) begin
            if (idx_q == AW'(ENTRIES - 1)) idx_q <= '0;
            else                           idx_q <= idx_q + 1'b1;
        end
    end

    assign idx  = idx_q;
    assign word = table_w[idx_q];

    // R4
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && idx_q == AW'(ENTRIES - 1)) |=> (idx_q == '0));

endmodule

// File: rtl/glow_timer.sv
module glow_timer #(
    parameter int HOLD_CYCLES = 150_000_000,
    parameter int LED_W       = 9,
    localparam int CW         = $clog2(HOLD_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic [LED_W-1:0] led
);
    logic [CW-1:0] left_q;
    logic          lit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             left_q <= '0;
        else if (load)          left_q <= CW'(HOLD_CYCLES);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign lit = (left_q != '0);
    assign led = {LED_W{lit}};

    // R9
    glow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> lit);

    // R8
    glow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !lit) |=> !lit);

endmodule

// File: rtl/quiz_ctrl.sv
module quiz_ctrl #(
    parameter int KEYS        = 4,
    parameter int ENTRIES     = 32,
    parameter int HOLD_CYCLES = 150_000_000,
    parameter int LED_W       = 9,
    localparam int SW         = $clog2(KEYS),
    localparam int AW         = $clog2(ENTRIES),
    localparam int WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEYS-1:0]   key_n,
    output logic [WORD_W-1:0] quiz_word,
    output logic [AW-1:0]     quiz_idx,
    output logic [SW-1:0]     ans_slot,
    output logic              next_q,
    output logic              answer_ok,
    output logic [LED_W-1:0]  glow_led
);
    import quiz_pkg::*;

    game_state_t     state_q, state_d;
    logic [KEYS-1:0] key_act;
    logic            any_key;
    logic [SW-1:0]   first_key;
    logic            grade;
    logic            hit;
    logic            capture;
    logic            upd_q;
    logic            ok_q;

    key_sync #(.KEYS(KEYS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_n   (key_n),
        .key_act (key_act)
    );

    assign any_key = |key_act;

    // lowest index wins among keys that are down together
    always_comb begin
        first_key = '0;
        for (int i = KEYS - 1; i >= 0; i--) begin
            if (key_act[i]) first_key = SW'(i);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_BOOT:      if (any_key)  state_d = GS_BOOT_HELD;
            GS_BOOT_HELD: if (!any_key) state_d = GS_READY;
            GS_READY:     if (any_key)  state_d = GS_HELD;
            GS_HELD:      if (!any_key) state_d = GS_READY;
        endcase
    end

    assign grade   = (state_q == GS_READY) && any_key;
    assign hit     = grade && (first_key == ans_slot);
    assign capture = ((state_q == GS_BOOT_HELD) || (state_q == GS_HELD)) && !any_key;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_BOOT;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
            ok_q  <= 1'b0;
        end else begin
            upd_q <= grade;
            if (grade) ok_q <= hit;
        end
    end

    slot_picker #(.SLOT_W(SW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .slot    (ans_slot)
    );

    exercise_rom #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (grade),
        .idx     (quiz_idx),
        .word    (quiz_word)
    );

    glow_timer #(.HOLD_CYCLES(HOLD_CYCLES), .LED_W(LED_W)) u_glow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hit),
        .led   (glow_led)
    );

    assign next_q    = upd_q;
    assign answer_ok = ok_q;

    // R4
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_q |=> !next_q);

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_q |-> (quiz_idx == AW'($past(quiz_idx) + 1'b1)));

    // R7
    ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !next_q |-> $stable(answer_ok));

    // R3
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_BOOT || state_q == GS_BOOT_HELD) |-> (!next_q && quiz_idx == '0 && !answer_ok));

endmodule

// File: tb/test_quiz_ctrl.sv
module test_quiz_ctrl;
    localparam int HOLD = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  key_n = 4'hF;
    logic [31:0] quiz_word;
    logic [4:0]  quiz_idx;
    logic [1:0]  ans_slot;
    logic        next_q;
    logic        answer_ok;
    logic [8:0]  glow_led;

    quiz_ctrl #(.HOLD_CYCLES(HOLD)) i_quiz_ctrl (
        .clk (clk), .rst_n (rst_n), .key_n (key_n),
        .quiz_word (quiz_word), .quiz_idx (quiz_idx), .ans_slot (ans_slot),
        .next_q (next_q), .answer_ok (answer_ok), .glow_led (glow_led)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int upd_cnt = 0;
    int glow_hi = 0;
    always @(negedge clk) begin
        if (next_q) upd_cnt++;
        if (glow_led != '0) glow_hi++;
    end

    int total = 0;
    int bad = 0;
    bit done = 0;
    int press_cyc, rel_cyc, last_rel, exp_idx;
    logic [31:0] word0;

    // {offset from slot, hold cycles, add keys late, expected ok}
    localparam logic [7:0] VEC [8] = '{
        {2'd0, 4'd4, 1'b0, 1'b1},
        {2'd1, 4'd5, 1'b0, 1'b0},
        {2'd0, 4'd7, 1'b1, 1'b1},
        {2'd2, 4'd6, 1'b0, 1'b0},
        {2'd3, 4'd9, 1'b1, 1'b0},
        {2'd0, 4'd8, 1'b0, 1'b1},
        {2'd1, 4'd4, 1'b1, 1'b0},
        {2'd0, 4'd5, 1'b0, 1'b1}
    };

    task automatic check_eq(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_word(logic [31:0] w);
        int a, b, r, e;
        a = int'(w[31:24]); b = int'(w[23:16]); r = int'(w[15:8]);
        case (w[7:0])
            8'd0: e = a + b;
            8'd1: e = a - b;
            8'd2: e = a * b;
            8'd3: e = (b != 0 && a % b == 0) ? a / b : -1;
            default: e = -2;
        endcase
        check_eq("R5 result field", r, e);
    endtask

    task automatic press(logic [3:0] mask, int hold, bit extra);
        @(negedge clk);
        press_cyc = cyc;
        key_n = ~mask;
        repeat (hold) @(negedge clk);
        if (extra) begin
            key_n = 4'h0;
            repeat (2) @(negedge clk);
        end
        key_n = 4'hF;
        rel_cyc = cyc;
        repeat (6) @(negedge clk);
    endtask

    task automatic graded(logic [3:0] mask, int hold, bit extra, bit exp_ok);
        int u0, s0, r0;
        u0 = upd_cnt; s0 = int'(ans_slot); r0 = last_rel;
        press(mask, hold, extra);
        exp_idx = (exp_idx + 1) % 32;
        check_eq("R7 answer_ok", int'(answer_ok), int'(exp_ok));
        check_eq("R4 next_q pulses", upd_cnt - u0, 1);
        check_eq("R4 quiz_idx", int'(quiz_idx), exp_idx);
        check_word(quiz_word);
        check_eq("R6 slot", int'(ans_slot), (s0 + rel_cyc - r0) % 4);
        last_rel = rel_cyc;
    endtask

    function automatic logic [3:0] key_at(int off);
        return 4'(1 << ((int'(ans_slot) + off) % 4));
    endfunction

    task automatic check_reset_state();
        check_eq("R1 quiz_idx", int'(quiz_idx), 0);
        check_eq("R1 ans_slot", int'(ans_slot), 0);
        check_eq("R1 answer_ok", int'(answer_ok), 0);
        check_eq("R1 next_q", int'(next_q), 0);
        check_eq("R1 glow_led", int'(glow_led), 0);
    endtask

    initial begin
        int u0, g0, p1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        word0 = quiz_word;
        check_eq("R1 quiz_word", int'(word0), int'(quiz_pkg::exercise_word(0)));
        check_word(word0);

        // R3 start press
        u0 = upd_cnt;
        press(4'b0001, 4, 1'b0);
        check_eq("R3 quiz_idx", int'(quiz_idx), 0);
        check_eq("R3 next_q", upd_cnt - u0, 0);
        check_eq("R3 answer_ok", int'(answer_ok), 0);
        check_eq("R3 glow_led", int'(glow_led), 0);
        last_rel = rel_cyc;
        exp_idx = 0;

        // vector table: R2 R4 R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            graded(key_at(int'(VEC[v][7:6])), int'(VEC[v][5:2]), VEC[v][1], VEC[v][0]);
        end

        // R2 all keys at once: key 0 wins
        graded(4'b1111, 5, 1'b0, ans_slot == 2'd0);

        // R8 exact duration
        repeat (HOLD + 5) @(negedge clk);
        check_eq("R8 glow off", int'(glow_led), 0);
        g0 = glow_hi;
        graded(key_at(0), 4, 1'b0, 1'b1);
        check_eq("R8 glow value", int'(glow_led), 9'h1FF);
        repeat (HOLD + 10) @(negedge clk);
        check_eq("R8 glow length", glow_hi - g0, HOLD);

        // R8 wrong answer leaves LEDs dark
        g0 = glow_hi;
        graded(key_at(2), 6, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check_eq("R8 wrong no glow", glow_hi - g0, 0);

        // R9 restart during glow
        g0 = glow_hi;
        graded(key_at(0), 4, 1'b0, 1'b1);
        p1 = press_cyc;
        graded(key_at(0), 5, 1'b0, 1'b1);
        repeat (HOLD + 10) @(negedge clk);
        check_eq("R9 glow restart", glow_hi - g0, (press_cyc - p1) + HOLD);

        // R4 wrap back to the first exercise
        while (exp_idx != 0) graded(key_at(1), 4, 1'b0, 1'b0);
        check_eq("R4 wrap word", int'(quiz_word), int'(word0));

        // R1 reset in mid game
        graded(key_at(0), 4, 1'b0, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule